// File: doc/BRIEF.md
# Snooping MSI Cache-Line Controller

This block is the coherence engine of a small direct-mapped write-back cache that shares a snooping bus with other caches. Each line holds one of three coherence states: Invalid (empty), Shared (valid, clean, read-only) or Modified (valid, dirty, exclusive, readable and writable). A valid bit and a dirty bit per line encode the state. The block serves processor reads and writes through a request/ready handshake. It issues read-miss, write-miss, invalidate and writeback transactions through a request/grant bus port. It watches the transactions of other caches on a snoop port and supplies dirty data whenever one of them touches a Modified line.

A bus transaction takes effect in the cycle it is granted, and fill data is taken from `bus_rdata` in that cycle. Writes are ordered by the bus: a write that needs other copies removed completes only in its grant cycle. When a miss evicts a dirty line, the miss goes on the bus first and the processor completes with it. The victim then waits in a one-entry writeback buffer, and its writeback is issued afterwards at lower priority. Only one transaction is outstanding, and no snoop is presented in a grant cycle.

Bus and snoop command codes share one 2-bit encoding: 00 writeback, 01 read miss, 10 write miss (read for ownership), 11 invalidate. The line index is the low address bits and the tag is the rest. Each data line is one word of `DATA_W` bits with one write strobe per byte.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_ready` are low, and the first access to any address misses.
- R2: A read to an Invalid line or a tag mismatch raises `bus_req` with command 01 and the processor address. `cpu_ready` and `cpu_rdata` = `bus_rdata` come in the grant cycle, and the line becomes Shared.
- R3: A read that hits a Shared or Modified line completes in the same cycle with the stored word and no bus request.
- R4: A write miss raises command 10 and merges the write bytes chosen by `cpu_wstrb` into the whole fetched word. It completes at the grant and leaves the line Modified.
- R5: A write hit on a Shared line raises command 11 and completes only at its grant, leaving the line Modified. If a snoop removes the line while the write waits, the command becomes 10.
- R6: A write hit on a Modified line completes in the same cycle with no bus request.
- R7: A snooped read miss (01) that matches a Modified line asserts `snp_flush` with the line's word in the same cycle and drops the line to Shared. A later local write to it then needs an invalidate.
- R8: A snooped write miss (10) or invalidate (11) that matches a line makes it Invalid. `snp_flush` is asserted with the word only if the line was Modified.
- R9: A miss that evicts a Modified line issues its own command first and completes at that grant. A writeback (00) of the victim address and word follows, and processor requests stall until it is granted.
- R10: A snooped 01, 10 or 11 that matches the address waiting in the writeback buffer flushes the buffered word, and that writeback is dropped.
- R11: A snoop on the same line index as the processor request holds `cpu_ready` low in that cycle. A snooped writeback (00) changes no line state and never flushes.
- R12: `cpu_ready` never rises for a request that needs the bus before its grant. While a request waits without a snoop, `bus_req` and `bus_addr` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_wstrb | input | DATA_W/8 | Byte write strobes |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | Transaction command (00 WB, 01 RD, 10 WR, 11 INV) |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Grant; the transaction takes effect this cycle |
| bus_rdata | input | DATA_W | Fill data from memory in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is visible |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |
| snp_data | output | DATA_W | Flushed word |

## Verification
The bench builds the controller with four lines, a 6-bit address and 16-bit words. With these values, addresses a few words apart collide on one index, so dirty victims, queued writebacks and snoops on the buffered victim come up often. The two byte strobes make a partial write's merge with the fetched word visible. The grant delay is varied between zero and four cycles. This opens windows where snoops land during a pending invalidate or writeback, and where a snoop hits the index the processor is using.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int LINES  = 16,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_wstrb,
  output logic                cpu_ready,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                bus_req,
  output logic [1:0]          bus_cmd,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_gnt,
  input  logic [DATA_W-1:0]   bus_rdata,
  input  logic                snp_valid,
  input  logic [1:0]          snp_cmd,
  input  logic [ADDR_W-1:0]   snp_addr,
  output logic                snp_flush,
  output logic [DATA_W-1:0]   snp_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int NB    = DATA_W / 8;
  localparam logic [1:0] CMD_WB = 2'b00, CMD_RD = 2'b01, CMD_WR = 2'b10, CMD_INV = 2'b11;

  logic [LINES-1:0]  vld_q, drt_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic              wb_pend_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q;

  logic [IDX_W-1:0]  c_idx, s_idx;
  logic [TAG_W-1:0]  c_tag, s_tag;
  logic              c_hit, c_need, c_fill, c_victim, stall;
  logic              s_hit, s_act, s_wb_hit;
  logic [1:0]        c_cmd;
  logic [DATA_W-1:0] base, merged;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  assign c_hit  = vld_q[c_idx] && (tag_q[c_idx] == c_tag);
  assign c_need = cpu_req && !(c_hit && (!cpu_we || drt_q[c_idx]));
  assign c_cmd  = !c_hit ? (cpu_we ? CMD_WR : CMD_RD) : CMD_INV;

  assign s_act    = snp_valid && (snp_cmd != CMD_WB);
  assign s_hit    = s_act && vld_q[s_idx] && (tag_q[s_idx] == s_tag);
  assign s_wb_hit = s_act && wb_pend_q && (snp_addr == wb_addr_q);
  assign stall    = snp_valid && (s_idx == c_idx);

  assign cpu_ready = !wb_pend_q && cpu_req && !stall && (!c_need || bus_gnt);
  assign c_fill    = cpu_ready && c_need;
  assign c_victim  = c_fill && !c_hit && vld_q[c_idx] && drt_q[c_idx];

  assign bus_req   = wb_pend_q || c_need;
  assign bus_cmd   = wb_pend_q ? CMD_WB : c_cmd;
  assign bus_addr  = wb_pend_q ? wb_addr_q : cpu_addr;
  assign bus_wdata = wb_data_q;

  assign base      = c_hit ? dat_q[c_idx] : bus_rdata;
  assign cpu_rdata = base;

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign merged[8*b +: 8] = cpu_wstrb[b] ? cpu_wdata[8*b +: 8] : base[8*b +: 8];
  end

  assign snp_flush = s_wb_hit || (s_hit && drt_q[s_idx]);
  assign snp_data  = s_wb_hit ? wb_data_q : dat_q[s_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= '0;
      drt_q     <= '0;
      wb_pend_q <= 1'b0;
    end else begin
      if (s_hit) begin
        drt_q[s_idx] <= 1'b0;
        if (snp_cmd != CMD_RD) vld_q[s_idx] <= 1'b0;
      end
      if (s_wb_hit || (wb_pend_q && bus_gnt)) wb_pend_q <= 1'b0;
      else if (c_victim)                      wb_pend_q <= 1'b1;
      if (cpu_ready) begin
        vld_q[c_idx] <= 1'b1;
        drt_q[c_idx] <= cpu_we || (c_hit && drt_q[c_idx]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (c_victim) begin
      wb_addr_q <= {tag_q[c_idx], c_idx};
      wb_data_q <= dat_q[c_idx];
    end
    if (cpu_ready && (cpu_we || c_need)) begin
      tag_q[c_idx] <= c_tag;
      dat_q[c_idx] <= cpu_we ? merged : base;
    end
  end
endmodule

// File: rtl/msi_line_ctrl_chk.sv
module msi_line_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_flush
);
  assert_ready_has_req_R12: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> cpu_req);

  assert_ready_after_grant_R12: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && bus_req) |-> bus_gnt);

  assert_request_held_R12: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_valid && bus_cmd != 2'b00) |=> (bus_req && $stable(bus_addr)));

  assert_inv_from_write_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == 2'b11) |-> (cpu_req && cpu_we));

  assert_wrmiss_from_write_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == 2'b10) |-> (cpu_req && cpu_we));

  assert_wb_stalls_cpu_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_cmd == 2'b00) |-> !cpu_ready);

  assert_flush_on_snoop_R11: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> (snp_valid && snp_cmd != 2'b00));
endmodule

bind msi_line_ctrl msi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_flush(snp_flush)
);

// File: tb/msi_line_ctrl_bench.sv
`timescale 1ns/1ps
module msi_line_ctrl_bench;
  localparam int LN = 4;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 0, rst = 1;
  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [1:0]    cpu_wstrb = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_gnt = 0;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_flush;
  logic [DW-1:0] snp_data;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(int a);
    return DW'((((a ^ 'hC3) & 'hFF) << 8) | ((a + 'h11) & 'hFF));
  endfunction

  assign bus_rdata = mem_word(int'(bus_addr));

  msi_line_ctrl #(.LINES(LN), .ADDR_W(AW), .DATA_W(DW)) u_msi_line_ctrl (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wstrb(cpu_wstrb), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_flush(snp_flush), .snp_data(snp_data));

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  bit            m_v [LN];
  bit            m_d [LN];
  int            m_tag [LN];
  logic [DW-1:0] m_dat [LN];
  bit            m_wbp = 0;
  int            m_wba = 0;
  logic [DW-1:0] m_wbd = '0;

  typedef struct {
    int ci; int si; bit hit; bit need; bit ready; bit req; logic [1:0] cmd; int addr;
    logic [DW-1:0] base; logic [DW-1:0] merge; bit lhit; bit wbhit; bit flush; logic [DW-1:0] sdata;
  } exp_t;

  function automatic exp_t model_eval();
    exp_t e;
    int ct, st;
    e.ci = int'(cpu_addr) % LN;  ct = int'(cpu_addr) / LN;
    e.si = int'(snp_addr) % LN;  st = int'(snp_addr) / LN;
    e.hit  = m_v[e.ci] && (m_tag[e.ci] == ct);
    e.need = cpu_req && !(e.hit && (!cpu_we || m_d[e.ci]));
    e.base = e.hit ? m_dat[e.ci] : mem_word(int'(cpu_addr));
    for (int b = 0; b < DW/8; b++)
      e.merge[8*b +: 8] = cpu_wstrb[b] ? cpu_wdata[8*b +: 8] : e.base[8*b +: 8];
    if (m_wbp) begin
      e.req = 1; e.cmd = 2'b00; e.addr = m_wba; e.ready = 0;
    end else begin
      e.req = e.need; e.addr = int'(cpu_addr);
      e.cmd = !e.hit ? (cpu_we ? 2'b10 : 2'b01) : 2'b11;
      e.ready = cpu_req && !(snp_valid && e.si == e.ci) && (!e.need || bus_gnt);
    end
    e.wbhit = snp_valid && snp_cmd != 2'b00 && m_wbp && int'(snp_addr) == m_wba;
    e.lhit  = snp_valid && snp_cmd != 2'b00 && m_v[e.si] && m_tag[e.si] == st;
    e.flush = e.wbhit || (e.lhit && m_d[e.si]);
    e.sdata = e.wbhit ? m_wbd : m_dat[e.si];
    return e;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LN; i++) begin m_v[i] = 0; m_d[i] = 0; end
      m_wbp = 0;
    end else begin
      exp_t e;
      e = model_eval();
      if (e.lhit) begin
        m_d[e.si] = 0;
        if (snp_cmd != 2'b01) m_v[e.si] = 0;
      end
      if (e.wbhit || (m_wbp && bus_gnt)) m_wbp = 0;
      if (e.ready) begin
        if (e.need && !e.hit && m_v[e.ci] && m_d[e.ci]) begin
          m_wbp = 1; m_wba = m_tag[e.ci] * LN + e.ci; m_wbd = m_dat[e.ci];
        end
        if (cpu_we || e.need) begin
          m_tag[e.ci] = int'(cpu_addr) / LN;
          m_dat[e.ci] = cpu_we ? e.merge : e.base;
        end
        m_d[e.ci] = cpu_we || (e.hit && m_d[e.ci]);
        m_v[e.ci] = 1;
      end
    end
  end

  task automatic chk(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      e = model_eval();
      chk("bus_req", DW'(bus_req), DW'(e.req));
      if (e.req) begin
        chk("bus_cmd", DW'(bus_cmd), DW'(e.cmd));
        chk("bus_addr", DW'(bus_addr), DW'(e.addr));
        if (e.cmd == 2'b00) chk("bus_wdata", bus_wdata, m_wbd);
      end
      chk("cpu_ready", DW'(cpu_ready), DW'(e.ready));
      if (e.ready && !cpu_we) chk("cpu_rdata", cpu_rdata, e.base);
      chk("snp_flush", DW'(snp_flush), DW'(e.flush));
      if (e.flush) chk("snp_data", snp_data, e.sdata);
    end
  end

  int age = 0;
  int gnt_wait = 1;
  always @(negedge clk) begin
    if (rst || bus_gnt) age = 0;
    else if (bus_req)   age = age + 1;
    else                age = 0;
  end
  always @(posedge clk) begin
    #2;
    bus_gnt = (age > 0) && (age >= gnt_wait) && !snp_valid;
  end

  task automatic cpu_op(bit we, int a, logic [DW-1:0] d, logic [1:0] s);
    @(posedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d; cpu_wstrb = s;
    for (int k = 0; ; k++) begin
      @(negedge clk);
      if (cpu_ready) break;
      if (k > 300) begin
        n_cmp++; n_bad++;
        $display("FAIL %s request watchdog: actual no ready expected ready", cur_req);
        break;
      end
    end
    @(posedge clk); #1;
    cpu_req = 0;
  endtask

  task automatic snoop(int dly, logic [1:0] c, int a);
    repeat (dly) @(posedge clk);
    @(posedge clk); #1;
    snp_valid = 1; snp_cmd = c; snp_addr = AW'(a);
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL %s global watchdog: actual hung expected finished", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 0;
    cur_req = "R1"; repeat (3) @(posedge clk);
    gnt_wait = 2;
    cpu_op(0, 'h05, '0, 2'b00);                 // R1 / R2: first read misses
    cur_req = "R3"; cpu_op(0, 'h05, '0, 2'b00);
    cur_req = "R4"; cpu_op(1, 'h06, 16'hBEEF, 2'b01);
    cur_req = "R6"; cpu_op(1, 'h06, 16'h1200, 2'b10);
    cur_req = "R3"; cpu_op(0, 'h06, '0, 2'b00);
    cur_req = "R5"; cpu_op(1, 'h05, 16'h7777, 2'b11);
    cur_req = "R7"; snoop(0, 2'b01, 'h06);
    cpu_op(1, 'h06, 16'h0055, 2'b01);           // R7: needs invalidate now
    cur_req = "R8"; snoop(0, 2'b11, 'h05);
    snoop(0, 2'b01, 'h06);
    snoop(0, 2'b10, 'h06);
    cpu_op(0, 'h06, '0, 2'b00);
    cur_req = "R9"; gnt_wait = 1;
    cpu_op(1, 'h0D, 16'hA1B2, 2'b11);
    cpu_op(0, 'h11, '0, 2'b00);
    cpu_op(0, 'h02, '0, 2'b00);
    cur_req = "R10"; cpu_op(1, 'h15, 16'h3C3C, 2'b10);
    gnt_wait = 4;
    cpu_op(0, 'h19, '0, 2'b00);
    snoop(0, 2'b10, 'h15);
    repeat (6) @(posedge clk);
    cur_req = "R11";
    fork cpu_op(0, 'h19, '0, 2'b00); snoop(0, 2'b00, 'h19); join
    fork cpu_op(0, 'h1A, '0, 2'b00); snoop(0, 2'b01, 'h02); join
    cur_req = "R5"; gnt_wait = 4;
    fork cpu_op(1, 'h19, 16'h6006, 2'b01); snoop(1, 2'b10, 'h19); join
    cur_req = "R12";
    for (int i = 0; i < 600; i++) begin
      int a = $urandom_range(0, 23);
      bit we = $urandom_range(0, 1) == 1;
      logic [DW-1:0] d = DW'($urandom);
      logic [1:0] s = 2'($urandom_range(0, 3));
      gnt_wait = $urandom_range(0, 4);
      if ($urandom_range(0, 3) == 0)
        fork cpu_op(we, a, d, s); snoop($urandom_range(0, 3), 2'($urandom_range(0, 3)), $urandom_range(0, 23)); join
      else
        cpu_op(we, a, d, s);
    end
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule